// File: doc/BRIEF.md
# Cascadable Bit-Serial Configuration Store

This block is a read-only memory that hands out its contents one bit at a time to a configuration master over a single data wire. It has no address input. An internal pointer starts at bit zero and moves forward by one on each rising clock edge while the block is selected. The bit at the current pointer is presented on the data output, so the master samples it on the next rising edge. The contents are fixed at elaboration through a parameter vector, and bit k of that vector is the k-th bit sent.

A single control pin acts as both output enable and pointer reset. A parameter selects whether its reset level is high or low. Several instances share the clock and the data wire, and each instance's chain-enable output feeds the chip enable of the next instance. A long bitstream can therefore span the whole chain. When an instance has sent its last bit, it releases the data wire and passes control on. The data output is modelled as a value plus a drive enable, so the surrounding logic can resolve the shared wire.

Top module: `serial_cfg_store`

## Requirements
- R1: While chip_en is high, the block is out of reset and it has not yet sent all DEPTH bits, each rising clock edge moves the read pointer forward by exactly one.
- R2: While data_oe is high, data_out equals bit p of CONTENT, where p is the number of pointer advances since the last reset; bit 0 of CONTENT is sent first.
- R3: data_oe is high only while chip_en is high, the block is out of reset and fewer than DEPTH bits have been sent. Otherwise data_oe is low and data_out is 0.
- R4: chain_en_out is high exactly when chip_en is high, the block is out of reset and all DEPTH bits have been sent. It is never high together with data_oe.
- R5: After the last bit, further clock edges neither wrap the pointer nor change the outputs until a reset.
- R6: With RST_ACTIVE_HIGH=1 the reset level of oe_rst is 1; with RST_ACTIVE_HIGH=0 it is 0. While oe_rst is at its reset level, the pointer is zero, data_oe is 0 and chain_en_out is 0, taking effect without waiting for a clock edge.
- R7: While chip_en is low, clock edges leave the pointer unchanged, so the stream resumes at the same bit once chip_en returns high.
- R8: Two instances chained through chain_en_out into chip_en, sharing clock, oe_rst and the data wire, send the first instance's CONTENT followed by the second's, with at most one of them driving in any cycle.
- R9: A reset in the middle of the stream, of either polarity, restarts the chained stream from bit 0 of the first instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the configuration master |
| chip_en | input | 1 | Selects this instance (active high) |
| oe_rst | input | 1 | Combined output enable and pointer reset; reset level set by RST_ACTIVE_HIGH |
| data_out | output | 1 | Serial data bit at the current pointer |
| data_oe | output | 1 | Drive enable for data_out onto the shared wire |
| chain_en_out | output | 1 | Enables the next instance once this one has finished |

## Verification
The difficult cycle is the handover. At one clock edge the first instance sends its last bit and raises chain_en_out, and the second instance must begin driving its bit zero with neither instance advancing twice. Two chains are built, one for each reset polarity and with different depth splits. Each is driven with random chip-enable pauses and random resets, including resets that land exactly on the handover edge and pauses that hold the handover. A bench model of the concatenated stream position judges every cycle. It checks the resolved wire value, checks that the two drive enables are never high together, and checks the end-of-chain enable.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  // Width of a pointer able to index `depth` bits (at least 1).
  function automatic int unsigned ptr_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  typedef struct packed {
    logic bit_val;
    logic drive;
  } wire_drv_t;
endpackage

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr
  import cfg_store_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = ptr_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_b,
  input  logic          step_en,
  output logic [AW-1:0] ptr,
  output logic          finished
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_nx;
  logic          fin_q, fin_nx;

  always_comb begin
    ptr_nx = ptr_q;
    fin_nx = fin_q;
    if (!fin_q) begin
      if (ptr_q == LAST) fin_nx = 1'b1;
      else               ptr_nx = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) begin
      ptr_q <= '0;
      fin_q <= 1'b0;
    end else if (step_en) begin
      ptr_q <= ptr_nx;
      fin_q <= fin_nx;
    end
  end

  assign ptr      = ptr_q;
  assign finished = fin_q;
endmodule

// File: rtl/cfg_bit_drive.sv
module cfg_bit_drive
  import cfg_store_pkg::*;
#(
  parameter int unsigned          DEPTH   = 64,
  parameter logic [DEPTH-1:0]     CONTENT = '0,
  localparam int unsigned         AW      = ptr_width(DEPTH)
) (
  input  logic [AW-1:0] ptr,
  input  logic          active,
  output wire_drv_t     drv
);
  logic sel_bit;

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (ptr == AW'(i)) sel_bit = CONTENT[i];
    end
  end

  always_comb begin
    drv.drive   = active;
    drv.bit_val = active & sel_bit;
  end
endmodule

// File: rtl/serial_cfg_store.sv
module serial_cfg_store
  import cfg_store_pkg::*;
#(
  parameter int unsigned      DEPTH           = 64,
  parameter logic [DEPTH-1:0] CONTENT         = {DEPTH{1'b0}},
  parameter bit               RST_ACTIVE_HIGH = 1'b0
) (
  input  logic clk,
  input  logic chip_en,
  input  logic oe_rst,
  output logic data_out,
  output logic data_oe,
  output logic chain_en_out
);
  localparam int unsigned AW = ptr_width(DEPTH);

  logic          rst_b;
  logic [AW-1:0] addr;
  logic          done;
  logic          active;
  wire_drv_t     drv;

  generate
    if (RST_ACTIVE_HIGH) begin : g_rst_hi
      assign rst_b = ~oe_rst;
    end else begin : g_rst_lo
      assign rst_b = oe_rst;
    end
  endgenerate

  cfg_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk      (clk),
    .rst_b    (rst_b),
    .step_en  (chip_en),
    .ptr      (addr),
    .finished (done)
  );

  assign active = chip_en & rst_b & ~done;

  cfg_bit_drive #(.DEPTH(DEPTH), .CONTENT(CONTENT)) u_drv (
    .ptr    (addr),
    .active (active),
    .drv    (drv)
  );

  assign data_out     = drv.bit_val;
  assign data_oe      = drv.drive;
  assign chain_en_out = chip_en & rst_b & done;
endmodule

// File: rtl/serial_cfg_store_chk.sv
module serial_cfg_store_chk
  import cfg_store_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = ptr_width(DEPTH)
) (
  input logic          clk,
  input logic          rst_b,
  input logic          chip_en,
  input logic [AW-1:0] addr,
  input logic          done,
  input logic          data_oe,
  input logic          chain_en_out
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_b)
    chip_en && !done && addr != LAST |=> addr == $past(addr) + 1'b1); // R1

  AST_LAST_TO_END: assert property (@(posedge clk) disable iff (!rst_b)
    chip_en && !done && addr == LAST |=> done); // R4

  AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_b)
    done |=> done && addr == LAST); // R5

  AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_b)
    !chip_en |=> $stable(addr) && $stable(done)); // R7

  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_b)
    !(data_oe && chain_en_out)); // R4

  AST_CEO_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_b)
    chain_en_out |-> chip_en); // R4

  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_b)
    data_oe |-> chip_en && !done); // R3

  always @(posedge clk) begin
    if (!rst_b) begin
      AST_RST_ZERO: assert (addr == '0 && !done && !data_oe && !chain_en_out); // R6
    end
  end
endmodule

bind serial_cfg_store serial_cfg_store_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_b        (rst_b),
  .chip_en      (chip_en),
  .addr         (addr),
  .done         (done),
  .data_oe      (data_oe),
  .chain_en_out (chain_en_out)
);

// File: tb/serial_cfg_store_tb.sv
module serial_cfg_store_tb;
  localparam int unsigned A0D = 40, A1D = 24;
  localparam int unsigned B0D = 24, B1D = 40;
  localparam int unsigned TOT = 64;
  localparam logic [A0D-1:0] A0C = 40'hA5_3C96_0F1E;
  localparam logic [A1D-1:0] A1C = 24'h5B_E127;
  localparam logic [B0D-1:0] B0C = 24'hC3_0FF1;
  localparam logic [B1D-1:0] B1C = 40'h1E_D24B_7A69;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic ce, rst;            // logical controls shared by both chains
  logic pin_a, pin_b;       // chain A resets low, chain B resets high
  assign pin_a = ~rst;
  assign pin_b = rst;

  logic a0_d, a0_oe, a0_ceo, a1_d, a1_oe, a1_ceo;
  logic b0_d, b0_oe, b0_ceo, b1_d, b1_oe, b1_ceo;

  serial_cfg_store #(.DEPTH(A0D), .CONTENT(A0C), .RST_ACTIVE_HIGH(1'b0)) u_dut (
    .clk(clk), .chip_en(ce), .oe_rst(pin_a),
    .data_out(a0_d), .data_oe(a0_oe), .chain_en_out(a0_ceo));
  serial_cfg_store #(.DEPTH(A1D), .CONTENT(A1C), .RST_ACTIVE_HIGH(1'b0)) u_a1 (
    .clk(clk), .chip_en(a0_ceo), .oe_rst(pin_a),
    .data_out(a1_d), .data_oe(a1_oe), .chain_en_out(a1_ceo));
  serial_cfg_store #(.DEPTH(B0D), .CONTENT(B0C), .RST_ACTIVE_HIGH(1'b1)) u_b0 (
    .clk(clk), .chip_en(ce), .oe_rst(pin_b),
    .data_out(b0_d), .data_oe(b0_oe), .chain_en_out(b0_ceo));
  serial_cfg_store #(.DEPTH(B1D), .CONTENT(B1C), .RST_ACTIVE_HIGH(1'b1)) u_b1 (
    .clk(clk), .chip_en(b0_ceo), .oe_rst(pin_b),
    .data_out(b1_d), .data_oe(b1_oe), .chain_en_out(b1_ceo));

  int n_chk = 0, n_fail = 0;
  int pos = 0;   // bench model: bits sent since reset

  function automatic logic exp_bit(input bit chain_b, input int p);
    if (!chain_b) return (p < A0D) ? A0C[p] : A1C[p - A0D];
    else          return (p < B0D) ? B0C[p] : B1C[p - B0D];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (pos=%0d t=%0t)", req, act, exp, pos, $time);
    end
  endtask

  task automatic check_chain(input bit cb, input logic d0, oe0, ceo0, d1, oe1, ceo1);
    int split = cb ? B0D : A0D;
    bit live  = ce && !rst;
    bit e_oe0 = live && pos < split;
    bit e_oe1 = live && pos >= split && pos < TOT;
    bit e_end = live && pos >= TOT;
    chk(!(oe0 && oe1), "R8 single driver", oe0 + oe1, 1);
    chk(oe0 == e_oe0, rst ? "R6 oe0" : "R3 oe0", oe0, e_oe0);
    chk(oe1 == e_oe1, rst ? "R6 oe1" : "R3 oe1", oe1, e_oe1);
    chk(ceo0 == (live && pos >= split), "R4 handover enable", ceo0, live && pos >= split);
    chk(ceo1 == e_end, "R4 chain end enable", ceo1, e_end);
    if (e_oe0 || e_oe1)
      chk((oe0 ? d0 : d1) == exp_bit(cb, pos), "R2 R8 stream bit", oe0 ? d0 : d1, exp_bit(cb, pos));
    else
      chk(!d0 && !d1, "R3 released data zero", d0 | d1, 0);
  endtask

  // drive inputs at negedge, check settled outputs, then let the posedge act
  task automatic step(input logic c, input logic r);
    @(negedge clk);
    ce = c; rst = r;
    if (r) pos = 0;
    #1;
    check_chain(1'b0, a0_d, a0_oe, a0_ceo, a1_d, a1_oe, a1_ceo);
    check_chain(1'b1, b0_d, b0_oe, b0_ceo, b1_d, b1_oe, b1_ceo);
    @(posedge clk);
    if (c && !r && pos < TOT + 1) pos++;
    if (pos > TOT) pos = TOT;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    ce = 1'b0; rst = 1'b1;
    // R6: reset state for both polarities
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    // R1 R2 R8: full stream with handover, then R5: extra clocks past the end
    for (int i = 0; i < TOT + 6; i++) step(1'b1, 1'b0);
    // R9: restart from bit 0 after finishing
    step(1'b1, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    // R7: pause holds position
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    // R9: reset mid-stream then run to the handover edges
    step(1'b1, 1'b1);
    for (int i = 0; i < 23; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);               // pause at chain B split
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);               // reset right at the handover
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);               // pause at chain A split
    step(1'b1, 1'b0);
    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) != 0, ($urandom % 97) == 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule